// File: doc/BRIEF.md
# ATA PIO Cycle Timing Generator

This block shapes the three phases of a programmed-I/O or multiword-DMA register cycle on an ATA-style channel pair. Four drives are served, two per channel: drives 0 and 1 sit on the primary channel and drives 2 and 3 on the secondary. Software writes one timing byte per drive that sets the strobe-active and recovery lengths. It also writes address-setup bytes. The primary channel has one setup byte per drive. The secondary channel has a single shared byte, which also carries unrelated control bits, among them an interrupt-pending flag at bit 4.

A requester presents a drive number and a direction. When the block is idle it accepts the request and captures that drive's decoded counts. It then holds the strobes low for the setup phase, raises the read or write strobe for the active phase, and drops it again for recovery. One clock of done follows. The ready output stays low from acceptance through the done clock, so a request can only start from the idle state.

Top module: `pio_cycle_timer`

## Requirements
- R1: After reset, timing bytes at addresses 0 to 3 read 0x3F, setup bytes at addresses 4, 5 and 6 read 0x40, `req_ready` is high and all strobes and `cyc_done` are low.
- R2: An accepted cycle runs in a fixed order. First comes setup with no strobe. Then active, with `wr_stb` high for a write (`req_write`=1) or `rd_stb` high for a read. Then recovery with no strobe. Then `cyc_done` high for exactly one clock, after which `req_ready` returns.
- R3: The active phase lasts N clocks for a nonzero upper nibble N of the drive's timing byte, and 16 clocks when that nibble is 0.
- R4: The recovery phase length is set by the lower nibble of the timing byte: 0 gives 16 clocks, 15 gives 1 clock, and any value V from 1 to 14 gives V+1 clocks.
- R5: The setup phase length comes from bits 7:6 of the setup byte in effect: 01 gives 2 clocks, 10 gives 3, 00 gives 4 and 11 gives 5.
- R6: A cycle for drive 0 or drive 1 uses the larger of the setup lengths decoded from address 4 (drive 0) and address 5 (drive 1).
- R7: Drives 2 and 3 both take their setup length from the shared byte at address 6. Bits 5:0 of that byte, including the flag at bit 4, are stored and read back unchanged and do not change any phase length.
- R8: `req_ready` is high only when idle. A request is taken on a clock where `req_valid` and `req_ready` are both high. `req_valid` while not ready has no effect.
- R9: The lengths of a cycle are fixed by the register contents before its accepting edge. A write on that edge or during the cycle affects only later cycles.
- R10: Register map: addresses 0 to 3 hold the timing bytes of drives 0 to 3, and addresses 4 to 6 hold the setup bytes. Address 7 reads 0x00 and writes to it are dropped. `reg_rdata` shows the addressed byte combinationally.
- R11: `rd_stb` and `wr_stb` are never high together, and neither is high outside the active phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Cycle request |
| req_drive | input | 2 | Drive number; bit 1 selects the channel |
| req_write | input | 1 | 1 for a write cycle, 0 for a read |
| req_ready | output | 1 | Idle and able to accept a request |
| rd_stb | output | 1 | Read strobe, high during the active phase of a read |
| wr_stb | output | 1 | Write strobe, high during the active phase of a write |
| cyc_done | output | 1 | One-clock pulse at the end of a cycle |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 3 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |

## Verification
The bench builds the block with its default parameters: four drives, a three-bit register address and five-bit phase counters. With those values every one of the 16 active codes, the 16 recovery codes and the 4 setup codes can be driven in turn. That includes the 16-clock extremes, which only the widest counter value holds. The same build also covers all 16 pairings of the two primary setup codes. It covers writes that land on the accepting edge or mid-cycle, and a request held high through back-to-back cycles, all against a clock-by-clock model of the expected strobes, ready and done.

// File: rtl/pio_timing_pkg.sv
package pio_timing_pkg;

    localparam int BYTE_W      = 8;
    localparam int NIB_W       = 4;
    localparam int CNT_W       = 5;
    localparam int DRV_PER_CH  = 2;
    localparam int NUM_CH      = 2;
    localparam int NUM_DRV     = DRV_PER_CH * NUM_CH;
    localparam int NUM_SETUP   = DRV_PER_CH + 1;
    localparam int ADDR_W      = 3;
    localparam int MAX_PHASE   = 16;

    localparam logic [BYTE_W-1:0] TIMING_RST = 8'h3F;
    localparam logic [BYTE_W-1:0] SETUP_RST  = 8'h40;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACTIVE,
        PH_RECOV,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] active;
        logic [CNT_W-1:0] recov;
    } cyc_cnt_t;

    function automatic logic [CNT_W-1:0] dec_active(input logic [NIB_W-1:0] nib);
        if (nib == '0) return CNT_W'(MAX_PHASE);
        return CNT_W'(nib);
    endfunction

    function automatic logic [CNT_W-1:0] dec_recov(input logic [NIB_W-1:0] nib);
        if (nib == '0)   return CNT_W'(MAX_PHASE);
        if (nib == '1)   return CNT_W'(1);
        return CNT_W'(nib) + CNT_W'(1);
    endfunction

    function automatic logic [CNT_W-1:0] dec_setup(input logic [1:0] code);
        case (code)
            2'b01:   return CNT_W'(2);
            2'b10:   return CNT_W'(3);
            2'b00:   return CNT_W'(4);
            default: return CNT_W'(5);
        endcase
    endfunction

endpackage

// File: rtl/pio_timing_regs.sv
module pio_timing_regs
    import pio_timing_pkg::*;
#(
    parameter int N_DRV = NUM_DRV,
    parameter int A_W   = ADDR_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  reg_wr,
    input  logic [A_W-1:0]        reg_addr,
    input  logic [BYTE_W-1:0]     reg_wdata,
    output logic [BYTE_W-1:0]     reg_rdata,
    output logic [BYTE_W-1:0]     timing_bytes [N_DRV],
    output logic [1:0]            setup_codes  [NUM_SETUP]
);

    localparam int SETUP_BASE = N_DRV;

    logic [BYTE_W-1:0] timing_q [N_DRV];
    logic [BYTE_W-1:0] setup_q  [NUM_SETUP];

    for (genvar g = 0; g < N_DRV; g++) begin : g_timing
        always_ff @(posedge clk) begin
            if (rst)
                timing_q[g] <= TIMING_RST;
            else if (reg_wr && reg_addr == A_W'(g))
                timing_q[g] <= reg_wdata;
        end
        assign timing_bytes[g] = timing_q[g];
    end

    for (genvar g = 0; g < NUM_SETUP; g++) begin : g_setup
        always_ff @(posedge clk) begin
            if (rst)
                setup_q[g] <= SETUP_RST;
            else if (reg_wr && reg_addr == A_W'(SETUP_BASE + g))
                setup_q[g] <= reg_wdata;
        end
        assign setup_codes[g] = setup_q[g][7:6];
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < N_DRV; i++)
            if (reg_addr == A_W'(i)) reg_rdata = timing_q[i];
        for (int i = 0; i < NUM_SETUP; i++)
            if (reg_addr == A_W'(SETUP_BASE + i)) reg_rdata = setup_q[i];
    end

endmodule

// File: rtl/pio_timing_select.sv
module pio_timing_select
    import pio_timing_pkg::*;
#(
    parameter int N_DRV = NUM_DRV,
    localparam int DRV_W = $clog2(N_DRV)
) (
    input  logic [DRV_W-1:0]  drive,
    input  logic [BYTE_W-1:0] timing_bytes [N_DRV],
    input  logic [1:0]        setup_codes  [NUM_SETUP],
    output cyc_cnt_t          cnt
);

    logic [CNT_W-1:0] setup_len [NUM_SETUP];
    logic [CNT_W-1:0] primary_len;
    logic [BYTE_W-1:0] tbyte;

    for (genvar g = 0; g < NUM_SETUP; g++) begin : g_dec
        assign setup_len[g] = dec_setup(setup_codes[g]);
    end

    // Primary channel: slower of the two per-drive setup lengths.
    always_comb begin
        primary_len = setup_len[0];
        for (int i = 1; i < DRV_PER_CH; i++)
            if (setup_len[i] > primary_len) primary_len = setup_len[i];
    end

    assign tbyte      = timing_bytes[drive];
    assign cnt.setup  = drive[DRV_W-1] ? setup_len[NUM_SETUP-1] : primary_len;
    assign cnt.active = dec_active(tbyte[7:4]);
    assign cnt.recov  = dec_recov(tbyte[3:0]);

endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
    import pio_timing_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     req_valid,
    input  logic     req_write,
    input  cyc_cnt_t cnt_in,
    output logic     req_ready,
    output logic     rd_stb,
    output logic     wr_stb,
    output logic     cyc_done
);

    phase_e           phase_q;
    logic [CNT_W-1:0] left_q;
    logic [CNT_W-1:0] act_q;
    logic [CNT_W-1:0] rec_q;
    logic             dir_q;
    logic             last;

    assign last = (left_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            left_q  <= '0;
            act_q   <= '0;
            rec_q   <= '0;
            dir_q   <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: if (req_valid) begin
                    act_q   <= cnt_in.active;
                    rec_q   <= cnt_in.recov;
                    dir_q   <= req_write;
                    left_q  <= cnt_in.setup - CNT_W'(1);
                    phase_q <= PH_SETUP;
                end
                PH_SETUP: if (last) begin
                    left_q  <= act_q - CNT_W'(1);
                    phase_q <= PH_ACTIVE;
                end else begin
                    left_q <= left_q - CNT_W'(1);
                end
                PH_ACTIVE: if (last) begin
                    left_q  <= rec_q - CNT_W'(1);
                    phase_q <= PH_RECOV;
                end else begin
                    left_q <= left_q - CNT_W'(1);
                end
                PH_RECOV: if (last) begin
                    phase_q <= PH_DONE;
                end else begin
                    left_q <= left_q - CNT_W'(1);
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign req_ready = (phase_q == PH_IDLE);
    assign rd_stb    = (phase_q == PH_ACTIVE) && !dir_q;
    assign wr_stb    = (phase_q == PH_ACTIVE) &&  dir_q;
    assign cyc_done  = (phase_q == PH_DONE);

endmodule

// File: rtl/pio_cycle_timer.sv
module pio_cycle_timer
    import pio_timing_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_drive,
    input  logic              req_write,
    output logic              req_ready,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic              cyc_done,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata
);

    logic [BYTE_W-1:0] timing_bytes [NUM_DRV];
    logic [1:0]        setup_codes  [NUM_SETUP];
    cyc_cnt_t          sel_cnt;

    pio_timing_regs #(.N_DRV(NUM_DRV), .A_W(ADDR_W)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .timing_bytes (timing_bytes),
        .setup_codes  (setup_codes)
    );

    pio_timing_select #(.N_DRV(NUM_DRV)) u_sel (
        .drive        (req_drive),
        .timing_bytes (timing_bytes),
        .setup_codes  (setup_codes),
        .cnt          (sel_cnt)
    );

    pio_phase_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .cnt_in    (sel_cnt),
        .req_ready (req_ready),
        .rd_stb    (rd_stb),
        .wr_stb    (wr_stb),
        .cyc_done  (cyc_done)
    );

endmodule

// File: rtl/pio_cycle_timer_chk.sv
module pio_cycle_timer_chk
    import pio_timing_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic rd_stb,
    input logic wr_stb,
    input logic cyc_done
);

    logic       stb;
    logic [5:0] run_q;

    assign stb = rd_stb || wr_stb;

    always_ff @(posedge clk) begin
        if (rst)      run_q <= '0;
        else if (stb) run_q <= run_q + 6'd1;
        else          run_q <= '0;
    end

    AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(rd_stb && wr_stb));                                            // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!stb && !cyc_done));                              // R8

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);                        // R8

    AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        cyc_done |=> (req_ready && !cyc_done));                          // R2

    AST_DIR_STEADY: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> !wr_stb);                                             // R2

    AST_ACTIVE_MAX: assert property (@(posedge clk) disable iff (rst)
        stb |-> (run_q < 6'(MAX_PHASE)));                                // R3

    AST_RECOV_GAP: assert property (@(posedge clk) disable iff (rst)
        $fell(stb) |-> (!cyc_done && !req_ready));                       // R4

    AST_SETUP_GAP: assert property (@(posedge clk) disable iff (rst)
        $rose(stb) |-> (!$past(req_ready) && !$past(cyc_done)));         // R5

endmodule

bind pio_cycle_timer pio_cycle_timer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb),
    .cyc_done  (cyc_done)
);

// File: tb/pio_cycle_timer_tb.sv
`timescale 1ns/1ps
module pio_cycle_timer_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [1:0] req_drive = 2'd0;
    logic       req_write = 1'b0;
    logic       req_ready, rd_stb, wr_stb, cyc_done;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    finished = 0;
    string cur_tag  = "R2";

    // behavioural model state
    int       m_reg [8];
    bit [2:0] exq [$];   // {rd, wr, done} per expected busy clock

    always #2 clk = ~clk;

    pio_cycle_timer u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_drive(req_drive),
        .req_write(req_write), .req_ready(req_ready), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .cyc_done(cyc_done), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t",
                     tag, what, act, exp, $time);
        end
    endtask

    function automatic int len_setup(input int code);
        case (code)
            1: return 2;
            2: return 3;
            0: return 4;
            default: return 5;
        endcase
    endfunction

    function automatic int len_active(input int nib);
        return (nib == 0) ? 16 : nib;
    endfunction

    function automatic int len_recov(input int nib);
        if (nib == 0)  return 16;
        if (nib == 15) return 1;
        return nib + 1;
    endfunction

    function automatic int model_setup(input int d);
        int a, b;
        if (d >= 2) return len_setup((m_reg[6] >> 6) & 3);
        a = len_setup((m_reg[4] >> 6) & 3);
        b = len_setup((m_reg[5] >> 6) & 3);
        return (a > b) ? a : b;
    endfunction

    always @(negedge clk) begin
        bit [2:0] e;
        bit       exp_ready;
        if (rst) begin
            for (int i = 0; i < 4; i++) m_reg[i] = 'h3F;
            for (int i = 4; i < 7; i++) m_reg[i] = 'h40;
            m_reg[7] = 0;
            exq.delete();
        end else begin
            if (exq.size() > 0) begin
                e = exq.pop_front();
                exp_ready = 1'b0;
            end else begin
                e = 3'b000;
                exp_ready = 1'b1;
            end
            check(req_ready == exp_ready, "R8", "req_ready", req_ready, exp_ready);
            check({rd_stb, wr_stb} == e[2:1], cur_tag, "strobes {rd,wr}",
                  {rd_stb, wr_stb}, e[2:1]);
            check(cyc_done == e[0], cur_tag, "cyc_done", cyc_done, e[0]);
            check(reg_rdata == m_reg[reg_addr], "R10", "reg_rdata",
                  reg_rdata, m_reg[reg_addr]);
            if (req_valid && exp_ready) begin
                int s, a, r, d;
                d = req_drive;
                s = model_setup(d);
                a = len_active((m_reg[d] >> 4) & 15);
                r = len_recov(m_reg[d] & 15);
                repeat (s) exq.push_back(3'b000);
                repeat (a) exq.push_back(req_write ? 3'b010 : 3'b100);
                repeat (r) exq.push_back(3'b000);
                exq.push_back(3'b001);
            end
            if (reg_wr && reg_addr != 3'd7) m_reg[reg_addr] = reg_wdata;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_reg(input int a, input int d);
        reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = 8'(d);
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input int a, input int exp, input string tag);
        reg_addr = 3'(a);
        @(negedge clk);
        check(reg_rdata == 8'(exp), tag, "register readback", reg_rdata, exp);
        tick();
    endtask

    task automatic wait_idle();
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        tick();
    endtask

    task automatic run_req(input int d, input bit w);
        bit acc;
        req_valid = 1'b1; req_drive = 2'(d); req_write = w;
        forever begin
            @(negedge clk);
            acc = req_ready;
            tick();
            if (acc) break;
        end
        req_valid = 1'b0;
        wait_idle();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) tick();
        rst = 1'b0;
        tick();

        // R1: reset contents and idle outputs
        cur_tag = "R1";
        check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
        for (int i = 0; i < 4; i++) rd_check(i, 'h3F, "R1");
        for (int i = 4; i < 7; i++) rd_check(i, 'h40, "R1");

        // R2: default cycles, both directions
        cur_tag = "R2";
        run_req(0, 1'b0);
        run_req(3, 1'b1);

        // R3: every active nibble, minimal recovery
        cur_tag = "R3";
        for (int n = 0; n < 16; n++) begin
            wr_reg(2, (n << 4) | 'hF);
            run_req(2, 1'b1);
        end

        // R4: every recovery nibble
        cur_tag = "R4";
        for (int n = 0; n < 16; n++) begin
            wr_reg(3, 'h10 | n);
            run_req(3, 1'b0);
        end

        // R5: every setup code on the shared byte
        cur_tag = "R5";
        for (int c = 0; c < 4; c++) begin
            wr_reg(6, c << 6);
            run_req(2, 1'b0);
        end

        // R6: every pairing of primary setup codes, both drives
        cur_tag = "R6";
        wr_reg(0, 'h1F);
        wr_reg(1, 'h2E);
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                wr_reg(4, a << 6);
                wr_reg(5, b << 6);
                run_req(0, 1'b0);
                run_req(1, 1'b1);
            end
        end

        // R7: low bits of the shared byte, including the flag at bit 4
        cur_tag = "R7";
        wr_reg(6, 'h80 | 'h10);
        rd_check(6, 'h90, "R7");
        run_req(3, 1'b1);
        wr_reg(6, 'h80 | 'h2F);
        rd_check(6, 'hAF, "R7");
        run_req(2, 1'b0);
        run_req(3, 1'b0);

        // R8: request held high, drive changing every clock
        cur_tag = "R8";
        wr_reg(2, 'h21);
        for (int i = 0; i < 60; i++) begin
            req_valid = 1'b1; req_drive = 2'(i % 4); req_write = i[0];
            tick();
        end
        req_valid = 1'b0;
        wait_idle();

        // R9: write on the accepting edge and in mid-cycle
        cur_tag = "R9";
        wr_reg(1, 'h11);
        req_valid = 1'b1; req_drive = 2'd1; req_write = 1'b1;
        reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 8'hF0;
        tick();
        req_valid = 1'b0; reg_wr = 1'b0;
        tick();
        wr_reg(5, 'hC0);
        wr_reg(1, 'h52);
        wait_idle();
        run_req(1, 1'b0);

        // R10: unmapped address
        cur_tag = "R10";
        wr_reg(7, 'hFF);
        rd_check(7, 'h00, "R10");
        rd_check(1, 'h52, "R10");
        rd_check(5, 'hC0, "R10");

        // R11: strobe exclusivity is checked on every clock above
        cur_tag = "R11";
        run_req(1, 1'b1);
        run_req(1, 1'b0);

        repeat (3) tick();
        finish_run();
    end

endmodule